// File: doc/BRIEF.md
# Linked-Channel DMA Burst Mover

This block copies bytes from one address range to another over a simple synchronous memory port. Each transfer is a read at the source address followed by a write at the destination address. Software programs two channels through a write-only register port. For each channel it sets a burst length, a block size, a repeat count, how each side's address steps, and when each side's address snaps back to its programmed start. Only one channel is active at a time. Each trigger moves one burst. A trigger comes either from a pulse on `ext_trig` or from a register write.

A transaction is the programmed number of block repetitions. When a transaction finishes, the block sets a sticky done flag for that channel and disables the channel. If the channel's link bit is set, the partner channel is armed and enabled at once and becomes the target of later triggers. The two channels can therefore hand over to each other for ping-pong buffering.

Two faults set a sticky error flag and stop the channel:
- a trigger that arrives while a burst is still running;
- a bus error reported on the memory handshake.

Top module: `dma_link_engine`

## Requirements
- R1: Register writes decode `reg_addr[3]` as the channel and `reg_addr[2:0]` as the field:
  - 0 is control: bit 0 enable, bits 2:1 burst code, bits 4:3 source mode, bits 6:5 destination mode, bits 8:7 source reload, bits 10:9 destination reload, bit 11 link.
  - 1 is block size [15:0].
  - 2 is repeat count [7:0].
  - 3 is source start address.
  - 4 is destination start address.
  - 5 is trigger (data ignored).
  - 6 is flag clear: bit 0 clears done, bit 1 clears error.

  A control write with enable 1 while not busy arms that channel (loads start addresses and counters) and makes it the active channel.
- R2: After reset, `busy`, `mem_req`, all enables, all done flags and all error flags are low, and `active_ch` is 0.
- R3: A trigger accepted while idle on the enabled active channel moves one burst of 1, 2, 4 or 8 bytes (burst code 0..3). Each byte is read at the source address and then written at the destination address. A burst ends early at a block boundary.
- R4: `busy` is high from the cycle after a trigger is accepted until the write handshake of the burst's last byte completes. `mem_req` is high only while `busy` is high.
- R5: The block size field gives 1 to 65535 bytes; a value of 0 means 65536 bytes.
- R6: A repeat count N runs the block N times and then ends the transaction; a count of 0 repeats forever until the channel is disabled.
- R7: Each side steps its address after every byte. Mode 0 keeps the address static, mode 1 increments it, mode 2 decrements it, and mode 3 acts as static.
- R8: Each side has a reload code: 0 never reloads; 1 reloads at transaction end; 2 reloads at every block end; 3 reloads at every burst end. A reload replaces that byte's step with the programmed start address.
- R9: At transaction end the channel's done flag is set, its enable is cleared and `busy` falls.
- R10: A trigger on the enabled active channel while `busy` sets that channel's error flag, clears its enable and abandons the burst.
- R11: A handshake that returns `mem_berr` sets the active channel's error flag, clears its enable and ends the burst. A write that fails this way does not count as a moved byte.
- R12: When a channel with its link bit set ends its transaction, the partner channel is armed and enabled and becomes active.
- R13: Triggers are ignored (no memory access, `busy` stays low) when the active channel is disabled, and software triggers are ignored when addressed to the inactive channel.
- R14: Once `mem_req` is raised, it stays high with address and direction unchanged until `mem_valid` answers it, unless an error aborts the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Channel bit and field select |
| reg_wdata | input | RW (16) | Register write data |
| ext_trig | input | 1 | External trigger pulse for the active channel |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW (16) | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_valid | input | 1 | Access completion strobe |
| mem_rdata | input | 8 | Read data, valid with `mem_valid` |
| mem_berr | input | 1 | Bus error, valid with `mem_valid` |
| busy | output | 1 | Burst in progress |
| active_ch | output | 1 | Channel that receives triggers |
| chan_en | output | 2 | Per-channel enable state |
| done_flag | output | 2 | Sticky per-channel transaction-complete flags |
| err_flag | output | 2 | Sticky per-channel error flags |

## Verification
The bench drives randomly mixed burst lengths, block sizes, repeat counts, address modes and reload codes, and compares the whole memory image against a byte-level model after each transaction. A design with a wrong reload level or step sign would leave the wrong bytes at the wrong places in that image. Directed cases cover the following:
- a block size of zero, which a design reading it as one byte or zero bytes would finish early;
- an endless repeat, where a design that ends the transaction would raise done;
- a trigger that lands during a burst, and an address that reports a bus error, either of which a careless design would let continue;
- a linked handover, where a design that fails to swap channels would leave the partner idle and drop its triggers.

// File: rtl/dma_pkg.sv
// Shared constants and types for the linked-channel DMA mover.
// Assumes exactly two channels; the link feature pairs them.
package dma_pkg;
    localparam int NCH = 2;

    // register field selects (reg_addr[2:0])
    localparam logic [2:0] F_CTRL   = 3'd0;
    localparam logic [2:0] F_BLOCK  = 3'd1;
    localparam logic [2:0] F_REPEAT = 3'd2;
    localparam logic [2:0] F_SRC    = 3'd3;
    localparam logic [2:0] F_DST    = 3'd4;
    localparam logic [2:0] F_TRIG   = 3'd5;
    localparam logic [2:0] F_CLEAR  = 3'd6;

    // address step modes
    localparam logic [1:0] AM_UP   = 2'd1;
    localparam logic [1:0] AM_DOWN = 2'd2;

    // end-of-byte levels fed to the address units (0 = mid-burst)
    localparam logic [1:0] LV_NONE  = 2'd0;
    localparam logic [1:0] LV_TXN   = 2'd1;
    localparam logic [1:0] LV_BLOCK = 2'd2;
    localparam logic [1:0] LV_BURST = 2'd3;

    // control field, bits 11:1 of the control register
    typedef struct packed {
        logic       link;
        logic [1:0] drl;
        logic [1:0] srl;
        logic [1:0] dmode;
        logic [1:0] smode;
        logic [1:0] burst;
    } ctrl_t;

    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} st_e;
endpackage

// File: rtl/dma_cfg_bank.sv
// Configuration storage for one channel: control, block size, repeat
// count and the two start addresses. Write-only; the enable bit lives in
// the top module because hardware also changes it.
module dma_cfg_bank
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [2:0]    fld,
    input  logic [RW-1:0] wdata,
    output ctrl_t         ctrl,
    output logic [15:0]   blk,
    output logic [7:0]    rep,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst
);
    // capture field writes addressed to this channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            blk  <= '0;
            rep  <= '0;
            src  <= '0;
            dst  <= '0;
        end else if (wr) begin
            case (fld)
                F_CTRL:   ctrl <= ctrl_t'(wdata[11:1]);
                F_BLOCK:  blk  <= wdata[15:0];
                F_REPEAT: rep  <= wdata[7:0];
                F_SRC:    src  <= wdata[AW-1:0];
                F_DST:    dst  <= wdata[AW-1:0];
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/dma_addr_gen.sv
// Working address for one side (source or destination). Loads the start
// address on arm. After each moved byte it either steps by the mode or,
// when the reload code reaches the byte's end level, returns to start.
module dma_addr_gen
    import dma_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [1:0]    lvl,
    input  logic [1:0]    mode,
    input  logic [1:0]    rl,
    input  logic [AW-1:0] start,
    output logic [AW-1:0] cur
);
    logic reload;
    // reload when a nonzero policy covers this end level
    assign reload = (rl != 2'd0) && (lvl != LV_NONE) && (rl >= lvl);

    // advance, reload or load the working address
    always_ff @(posedge clk) begin
        if (!rst_n)         cur <= '0;
        else if (load)      cur <= start;
        else if (step) begin
            if (reload)               cur <= start;
            else if (mode == AM_UP)   cur <= cur + 1'b1;
            else if (mode == AM_DOWN) cur <= cur - 1'b1;
        end
    end
endmodule

// File: rtl/dma_link_engine.sv
// Two-channel, one-at-a-time DMA byte mover. Holds the per-channel
// enables and flags, the burst/block/repeat counters and the read-then-
// write sequencer. Assumes the memory answers each request with exactly
// one mem_valid pulse and that software does not rearm while busy.
module dma_link_engine
    import dma_pkg::*;
#(
    parameter int AW = 16,
    localparam int RW = (AW > 16) ? AW : 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [3:0]     reg_addr,
    input  logic [RW-1:0]  reg_wdata,
    input  logic           ext_trig,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [7:0]     mem_wdata,
    input  logic           mem_valid,
    input  logic [7:0]     mem_rdata,
    input  logic           mem_berr,
    output logic           busy,
    output logic           active_ch,
    output logic [NCH-1:0] chan_en,
    output logic [NCH-1:0] done_flag,
    output logic [NCH-1:0] err_flag
);
    ctrl_t         ctrl_a [NCH];
    logic [15:0]   blk_a  [NCH];
    logic [7:0]    rep_a  [NCH];
    logic [AW-1:0] src_a  [NCH];
    logic [AW-1:0] dst_a  [NCH];

    logic       wr_ch;
    logic [2:0] wr_fld;
    assign wr_ch  = reg_addr[3];
    assign wr_fld = reg_addr[2:0];

    for (genvar c = 0; c < NCH; c++) begin : g_bank
        dma_cfg_bank #(.AW(AW), .RW(RW)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .wr(reg_we && (wr_ch == 1'(c))), .fld(wr_fld), .wdata(reg_wdata),
            .ctrl(ctrl_a[c]), .blk(blk_a[c]), .rep(rep_a[c]),
            .src(src_a[c]), .dst(dst_a[c])
        );
    end

    st_e           state;
    logic          act;
    logic [NCH-1:0] en, done_q, err_q;
    logic [7:0]    dbuf;
    logic [16:0]   blk_left;
    logic [7:0]    rep_left;
    logic          rep_inf;
    logic [3:0]    bst_left;
    logic [AW-1:0] src_cur, dst_cur;
    ctrl_t         cc;

    function automatic logic [16:0] blk_len(input logic [15:0] b);
        return (b == 16'd0) ? 17'h10000 : {1'b0, b};
    endfunction

    // decode of triggers, byte completion and end levels
    logic trig, accept, collide, byte_ok, bus_fault;
    logic last_blk, last_bst, last_txn, txn_end, handover;
    logic arm_sw, arm, arm_ch, sel;
    logic [1:0] lvl;

    always_comb begin
        cc        = ctrl_a[act];
        trig      = en[act] && (ext_trig ||
                    (reg_we && wr_fld == F_TRIG && wr_ch == act));
        accept    = trig && (state == ST_IDLE);
        collide   = trig && (state != ST_IDLE);
        byte_ok   = (state == ST_WR) && mem_valid && !mem_berr && !collide;
        bus_fault = (state != ST_IDLE) && mem_valid && mem_berr && !collide;
        last_blk  = (blk_left == 17'd1);
        last_bst  = (bst_left == 4'd1) || last_blk;
        last_txn  = last_blk && !rep_inf && (rep_left == 8'd1);
        txn_end   = byte_ok && last_txn;
        handover  = txn_end && cc.link;
        arm_sw    = reg_we && wr_fld == F_CTRL && reg_wdata[0] && (state == ST_IDLE);
        arm       = arm_sw || handover;
        arm_ch    = handover ? ~act : wr_ch;
        sel       = arm ? arm_ch : act;
        if (!byte_ok)      lvl = LV_NONE;
        else if (last_txn) lvl = LV_TXN;
        else if (last_blk) lvl = LV_BLOCK;
        else if (last_bst) lvl = LV_BURST;
        else               lvl = LV_NONE;
    end

    dma_addr_gen #(.AW(AW)) u_src (
        .clk(clk), .rst_n(rst_n), .load(arm), .step(byte_ok), .lvl(lvl),
        .mode(cc.smode), .rl(cc.srl), .start(src_a[sel]), .cur(src_cur)
    );
    dma_addr_gen #(.AW(AW)) u_dst (
        .clk(clk), .rst_n(rst_n), .load(arm), .step(byte_ok), .lvl(lvl),
        .mode(cc.dmode), .rl(cc.drl), .start(dst_a[sel]), .cur(dst_cur)
    );

    // read-then-write sequencer for one burst
    always_ff @(posedge clk) begin
        if (!rst_n)       state <= ST_IDLE;
        else if (collide) state <= ST_IDLE;
        else case (state)
            ST_IDLE: if (accept) state <= ST_RD;
            ST_RD:   if (mem_valid) state <= mem_berr ? ST_IDLE : ST_WR;
            ST_WR:   if (mem_valid) state <= (mem_berr || last_bst) ? ST_IDLE : ST_RD;
            default: state <= ST_IDLE;
        endcase
    end

    // data byte held between the read and the write
    always_ff @(posedge clk) begin
        if (!rst_n) dbuf <= '0;
        else if (state == ST_RD && mem_valid) dbuf <= mem_rdata;
    end

    // burst, block and repeat counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_left <= '0;
            rep_left <= '0;
            rep_inf  <= 1'b0;
            bst_left <= '0;
        end else begin
            if (arm) begin
                blk_left <= blk_len(blk_a[arm_ch]);
                rep_left <= rep_a[arm_ch];
                rep_inf  <= (rep_a[arm_ch] == 8'd0);
            end else if (byte_ok) begin
                if (last_blk) begin
                    blk_left <= blk_len(blk_a[act]);
                    if (!rep_inf) rep_left <= rep_left - 8'd1;
                end else begin
                    blk_left <= blk_left - 17'd1;
                end
            end
            if (accept)       bst_left <= 4'd1 << cc.burst;
            else if (byte_ok) bst_left <= bst_left - 4'd1;
        end
    end

    // enables, active channel and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= '0;
            act    <= 1'b0;
            done_q <= '0;
            err_q  <= '0;
        end else begin
            if (reg_we && wr_fld == F_CTRL) en[wr_ch] <= reg_wdata[0];
            if (txn_end || collide || bus_fault) en[act] <= 1'b0;
            if (handover) en[~act] <= 1'b1;
            if (arm) act <= arm_ch;
            if (reg_we && wr_fld == F_CLEAR) begin
                if (reg_wdata[0]) done_q[wr_ch] <= 1'b0;
                if (reg_wdata[1]) err_q[wr_ch]  <= 1'b0;
            end
            if (txn_end) done_q[act] <= 1'b1;
            if (collide || bus_fault) err_q[act] <= 1'b1;
        end
    end

    assign busy      = (state != ST_IDLE);
    assign mem_req   = busy;
    assign mem_we    = (state == ST_WR);
    assign mem_addr  = (state == ST_WR) ? dst_cur : src_cur;
    assign mem_wdata = dbuf;
    assign active_ch = act;
    assign chan_en   = en;
    assign done_flag = done_q;
    assign err_flag  = err_q;
endmodule

// File: rtl/dma_link_engine_chk.sv
// Protocol and flag checks for dma_link_engine, bound to every instance.
module dma_link_engine_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_valid,
    input logic          busy,
    input logic [1:0]    done_flag,
    input logic [1:0]    err_flag
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (err_flag != $past(err_flag)) ||
            (mem_req && $stable(mem_addr) && $stable(mem_we)));  // R14

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);  // R4

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_flag & ~$past(done_flag)) != 2'b00) |-> !busy);  // R9

    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_flag & ~$past(err_flag)) != 2'b00) |-> !busy && !mem_req);  // R10
endmodule

bind dma_link_engine dma_link_engine_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .busy(busy),
    .done_flag(done_flag), .err_flag(err_flag)
);

// File: tb/dma_link_engine_tb.sv
module dma_link_engine_tb;
    localparam int AW = 16;
    localparam logic [15:0] BAD = 16'h0333;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        ext_trig = 1'b0;
    logic        mem_req, mem_we, busy, active_ch;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_valid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        mem_berr = 1'b0;
    logic [1:0]  chan_en, done_flag, err_flag;

    always #5 clk = ~clk;

    dma_link_engine #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ext_trig(ext_trig), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .mem_berr(mem_berr),
        .busy(busy), .active_ch(active_ch), .chan_en(chan_en),
        .done_flag(done_flag), .err_flag(err_flag)
    );

    logic [7:0] mem [1024];
    logic [7:0] exp_mem [1024];
    int dly = 0;

    // behavioural memory with 0..2 wait cycles per access
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_valid <= 1'b0;
            dly <= 0;
        end else if (mem_valid) begin
            mem_valid <= 1'b0;
            dly <= $urandom_range(0, 2);
        end else if (mem_req) begin
            if (dly == 0) begin
                mem_valid <= 1'b1;
                mem_berr  <= (mem_addr == BAD);
                mem_rdata <= mem[mem_addr[9:0]];
                if (mem_we && mem_addr != BAD) mem[mem_addr[9:0]] <= mem_wdata;
            end else dly <= dly - 1;
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
        end
    endtask

    // bench copy of each channel's programmed configuration
    int c_burst[2], c_sm[2], c_dm[2], c_srl[2], c_drl[2], c_link[2], c_blk[2], c_rep[2];
    logic [15:0] c_src[2], c_dst[2];
    // model state of the active transaction
    logic [15:0] m_src, m_dst;
    int m_blk, m_rep;
    bit m_inf, m_done;

    function automatic logic [15:0] next_addr(input logic [15:0] a, input int mode,
            input int rl, input int lvl, input logic [15:0] st);
        if (rl != 0 && lvl != 0 && rl >= lvl) return st;
        if (mode == 1) return a + 16'd1;
        if (mode == 2) return a - 16'd1;
        return a;
    endfunction

    function automatic int blk_bytes(input int b);
        return (b == 0) ? 65536 : b;
    endfunction

    task automatic model_arm(input int c);
        m_src = c_src[c]; m_dst = c_dst[c];
        m_blk = blk_bytes(c_blk[c]); m_rep = c_rep[c];
        m_inf = (c_rep[c] == 0); m_done = 0;
    endtask

    task automatic model_burst(input int c);
        int n = 1 << c_burst[c];
        for (int i = 0; i < n; i++) begin
            bit lb, lt, lbst;
            int lvl;
            exp_mem[m_dst[9:0]] = exp_mem[m_src[9:0]];
            lb   = (m_blk == 1);
            lt   = lb && !m_inf && (m_rep == 1);
            lbst = (i == n - 1) || lb;
            lvl  = lt ? 1 : lb ? 2 : lbst ? 3 : 0;
            m_src = next_addr(m_src, c_sm[c], c_srl[c], lvl, c_src[c]);
            m_dst = next_addr(m_dst, c_dm[c], c_drl[c], lvl, c_dst[c]);
            if (lb) begin
                m_blk = blk_bytes(c_blk[c]);
                if (!m_inf) m_rep--;
            end else m_blk--;
            if (lt) m_done = 1;
            if (lbst) break;
        end
    endtask

    task automatic wr(input int ch, input logic [2:0] f, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = {ch[0], f}; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // program a channel and arm it with a control write (R1)
    task automatic cfg_ch(input int c, input int burst, input int sm, input int dm,
            input int srl, input int drl, input int link, input int blk,
            input int rep, input logic [15:0] src, input logic [15:0] dst);
        c_burst[c] = burst; c_sm[c] = sm; c_dm[c] = dm; c_srl[c] = srl;
        c_drl[c] = drl; c_link[c] = link; c_blk[c] = blk; c_rep[c] = rep;
        c_src[c] = src; c_dst[c] = dst;
        wr(c, 3'd1, 16'(blk));
        wr(c, 3'd2, 16'(rep));
        wr(c, 3'd3, src);
        wr(c, 3'd4, dst);
        wr(c, 3'd0, {4'b0, link[0], drl[1:0], srl[1:0], dm[1:0], sm[1:0], burst[1:0], 1'b1});
        model_arm(c);
    endtask

    task automatic fire(input int c, input bit ext);
        if (ext) begin
            @(negedge clk); ext_trig = 1'b1;
            @(negedge clk); ext_trig = 1'b0;
        end else wr(c, 3'd5, 16'h0);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 400 && busy; k++) @(negedge clk);
    endtask

    task automatic mem_init();
        for (int i = 0; i < 1024; i++) begin
            mem[i] = 8'($urandom);
            exp_mem[i] = mem[i];
        end
    endtask

    task automatic cmp_mem(input string req);
        int bad_i = -1;
        for (int i = 0; i < 1024; i++)
            if (bad_i < 0 && mem[i] !== exp_mem[i]) bad_i = i;
        if (bad_i < 0) check(1, req, "memory image", 0, 0);
        else check(0, req, $sformatf("memory byte %0d", bad_i), mem[bad_i], exp_mem[bad_i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not end, got 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        mem_init();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        check(!busy && !mem_req, "R2", "busy/req after reset", int'(busy), 0);
        check(chan_en == 2'b00 && done_flag == 2'b00 && err_flag == 2'b00,
              "R2", "enable/flags after reset", int'({chan_en, done_flag, err_flag}), 0);
        check(active_ch == 1'b0, "R2", "active channel", int'(active_ch), 0);

        // R13 trigger with nothing enabled
        fire(0, 1);
        check(!busy, "R13", "busy after trigger to disabled channel", int'(busy), 0);

        // Directed: burst 4, block 8, repeat 1, increment both sides (R1 R3 R4)
        cfg_ch(0, 2, 1, 1, 0, 0, 0, 8, 1, 16'h0040, 16'h0240);
        check(chan_en == 2'b01 && active_ch == 1'b0, "R1", "arm enables channel 0",
              int'(chan_en), 1);
        fire(0, 1);
        check(busy, "R4", "busy after accepted trigger", int'(busy), 1);
        model_burst(0);
        wait_idle();
        check(done_flag == 2'b00, "R6", "done after first of two bursts", int'(done_flag), 0);
        fire(0, 0);
        model_burst(0);
        wait_idle();
        cmp_mem("R3/R7/R14");
        check(done_flag == 2'b01, "R9", "done flag at transaction end", int'(done_flag), 1);
        check(chan_en == 2'b00, "R9", "enable cleared at transaction end", int'(chan_en), 0);
        // R13 trigger after completion is ignored
        fire(0, 1);
        check(!busy, "R13", "busy after trigger to finished channel", int'(busy), 0);
        repeat (4) @(negedge clk);
        cmp_mem("R13");
        wr(0, 3'd6, 16'h3);
        check(done_flag == 2'b00, "R1", "done cleared by flag clear", int'(done_flag), 0);

        // Directed: reload source at every burst end (R8)
        cfg_ch(0, 2, 1, 1, 3, 0, 0, 8, 1, 16'h0050, 16'h0250);
        for (int t = 0; t < 2; t++) begin
            fire(0, 1); model_burst(0); wait_idle();
        end
        cmp_mem("R8");

        // Constrained random transactions (R3 R5 R6 R7 R8 R9)
        for (int it = 0; it < 14; it++) begin
            wr(0, 3'd6, 16'h3);
            cfg_ch(0, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                   $urandom_range(0, 3), $urandom_range(0, 3), 0,
                   $urandom_range(1, 20), $urandom_range(1, 3),
                   16'h0040 + 16'($urandom_range(0, 63)),
                   16'h0240 + 16'($urandom_range(0, 63)));
            for (int t = 0; t < 100 && !m_done; t++) begin
                fire(0, bit'($urandom_range(0, 1)));
                model_burst(0);
                wait_idle();
            end
            cmp_mem("R7/R8");
            check(done_flag[0] == 1'b1, "R6", "done after programmed repeats",
                  int'(done_flag[0]), 1);
        end

        // Block size field zero means 65536 bytes (R5)
        wr(0, 3'd6, 16'h3);
        cfg_ch(0, 3, 1, 1, 0, 0, 0, 0, 1, 16'h0010, 16'h0210);
        for (int t = 0; t < 3; t++) begin
            fire(0, 1); model_burst(0); wait_idle();
        end
        check(done_flag == 2'b00, "R5", "done with zero block size", int'(done_flag), 0);
        cmp_mem("R5");

        // Repeat count zero runs forever (R6)
        cfg_ch(0, 1, 1, 1, 0, 0, 0, 2, 0, 16'h0080, 16'h0280);
        for (int t = 0; t < 5; t++) begin
            fire(0, 0); model_burst(0); wait_idle();
        end
        check(done_flag == 2'b00, "R6", "done with endless repeat", int'(done_flag), 0);
        cmp_mem("R6");
        wr(0, 3'd0, 16'h0);
        fire(0, 1);
        check(!busy, "R13", "busy after disable", int'(busy), 0);

        // Trigger during a burst (R10)
        cfg_ch(0, 3, 1, 1, 0, 0, 0, 16, 1, 16'h0020, 16'h0220);
        fire(0, 1);
        @(negedge clk);
        fire(0, 1);
        check(err_flag == 2'b01, "R10", "error flag after overlapping trigger",
              int'(err_flag), 1);
        check(!busy && chan_en == 2'b00, "R10", "stopped after overlapping trigger",
              int'({busy, chan_en}), 0);
        check(done_flag == 2'b00, "R10", "no done after overlap", int'(done_flag), 0);
        repeat (4) @(negedge clk);
        wr(0, 3'd6, 16'h3);
        mem_init();

        // Bus error on the source read (R11)
        cfg_ch(0, 2, 1, 1, 0, 0, 0, 8, 1, BAD, 16'h0230);
        fire(0, 1);
        wait_idle();
        check(err_flag == 2'b01, "R11", "error flag after bus error", int'(err_flag), 1);
        check(chan_en == 2'b00, "R11", "enable cleared after bus error", int'(chan_en), 0);
        cmp_mem("R11");
        wr(0, 3'd6, 16'h3);

        // Linked ping-pong handover (R12 R13)
        cfg_ch(1, 1, 1, 1, 0, 0, 1, 4, 1, 16'h0030, 16'h0300);
        cfg_ch(0, 2, 1, 1, 0, 0, 1, 4, 1, 16'h0010, 16'h02C0);
        check(active_ch == 1'b0, "R12", "channel 0 active after arm", int'(active_ch), 0);
        fire(0, 1); model_burst(0); wait_idle();
        check(active_ch == 1'b1 && chan_en == 2'b10, "R12", "handover to channel 1",
              int'({active_ch, chan_en}), 6);
        check(done_flag == 2'b01, "R12", "channel 0 done", int'(done_flag), 1);
        model_arm(1);
        fire(0, 0);
        check(!busy, "R13", "software trigger to inactive channel", int'(busy), 0);
        for (int t = 0; t < 2; t++) begin
            fire(1, bit'(t)); model_burst(1); wait_idle();
        end
        check(active_ch == 1'b0 && chan_en == 2'b01, "R12", "handover back to channel 0",
              int'({active_ch, chan_en}), 1);
        check(done_flag == 2'b11, "R12", "both channels done", int'(done_flag), 3);
        cmp_mem("R12");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule